// File: doc/BRIEF.md
# Timed Event Submission Register Front End

This block sits on a CPU's memory-mapped bus and turns a short burst of register writes into one timestamped output event for a downstream event queue. The CPU stages a 64-bit timestamp in two 32-bit halves, a packed target word, and one or more 32-bit data words. Writing the lowest data word submits the event. The submission is either handed to the queue of the selected core or refused with a bus error.

The timestamp is staged in a shadow register. It becomes visible as one unit only when its low half is written, so a reader never sees a torn value. The target word packs three fields: a core select, a channel number, and an address that is local to the channel's PHY. A full queue stalls the submitting write with wait states. A timestamp that is already in the past, a downed link or an unknown core ends the submitting write with a bus error. Sticky status flags record each of these conditions until software clears them.

Top module: `evt_submit_regs`

## Requirements
- R1: After reset, `bus_ack`, `bus_err` and `ev_push` are low. The status register (word 3) reads 0 and the committed timestamp reads 0.
- R2: A write to word 1 (timestamp high) only stages that half, and the committed timestamp read back from words 0/1 is unchanged. A write to word 0 (timestamp low) commits {staged high, written low} as one value.
- R3: The target register (word 2) is laid out as bits [31:24] core select, [23:8] channel, [7:0] PHY-local address. A submitted event drives `ev_channel` and `ev_addr` from those fields and pulses only the bit of `ev_push` indexed by the core field.
- R4: Writes to data words at addresses 5 and up are latched with no event pushed. A write to address 4 (data word 0) submits one event whose `ev_data` is {latched upper words, written word}. A small event therefore needs only four writes: timestamp high, timestamp low, target and data word 0.
- R5: A write to either timestamp half clears every latched data word. The cleared words read back as 0.
- R6: While the selected core's `fifo_full` is high, a submitting write gets neither ack nor error (wait states). It completes with exactly one push once the queue has room, and status bit 1 (wait flag) is set.
- R7: If the committed timestamp is less than `time_now` when data word 0 is written, the write ends with `bus_err`, no event is pushed, and status bit 0 (underflow) is set.
- R8: If the selected core has `link_down` high, or the core field is not below N_CORES, the submitting write ends with `bus_err`, no event is pushed, and status bit 2 (link error) is set. A downed link on another core has no effect.
- R9: Any write to the status register clears all three flags.
- R10: Every accepted access gets exactly one single-cycle response (`bus_ack` or `bus_err`, never both). At most one `ev_push` bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until a response |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completed normally |
| bus_err | output | 1 | Access completed with error |
| time_now | input | 64 | Free-running time counter |
| fifo_full | input | N_CORES | Per-core queue full |
| link_down | input | N_CORES | Per-core link failure |
| ev_push | output | N_CORES | One-hot event strobe per core |
| ev_timestamp | output | 64 | Event timestamp |
| ev_channel | output | 16 | Event channel |
| ev_addr | output | 8 | Event PHY-local address |
| ev_data | output | 32*DATA_WORDS | Event data |

## Verification
Random submissions vary the timestamp against `time_now`, the core field (including an out-of-range core) and the per-core link state. This separates the accept path from each of the two error paths, and it shows whether an error on one core leaks into another. Directed sequences test the ordering rules: writing the high half alone against writing the low half, a timestamp write between data writes, and latched upper words against the submit word. A queue held full for several cycles and then released shows whether stalled writes are held or dropped.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int unsigned REG_TS_LO  = 0;
   localparam int unsigned REG_TS_HI  = 1;
   localparam int unsigned REG_TARGET = 2;
   localparam int unsigned REG_STATUS = 3;
   localparam int unsigned REG_DATA0  = 4;

   localparam int unsigned FLAG_UNDERFLOW = 0;
   localparam int unsigned FLAG_WAIT      = 1;
   localparam int unsigned FLAG_LINK      = 2;
   localparam int unsigned N_FLAGS        = 3;

   typedef struct packed {
      logic [7:0]  core;
      logic [15:0] chan;
      logic [7:0]  addr;
   } target_t;
endpackage

// File: rtl/evt_ts_shadow.sv
module evt_ts_shadow (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [63:0] ts_commit
);
   logic [31:0] hi_stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_stage_q <= '0;
         ts_commit  <= '0;
      end else begin
         if (wr_hi) hi_stage_q <= wdata;
         if (wr_lo) ts_commit  <= {hi_stage_q, wdata};
      end
   end
endmodule

// File: rtl/evt_data_regs.sv
module evt_data_regs #(
   parameter int WORDS = 2,
   localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [31:0]       wdata,
   output logic [WORDS*32-1:0] words
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            word_q <= '0;
         else if (clr)                          word_q <= '0;
         else if (wr_en && wr_idx == IDXW'(g))  word_q <= wdata;
      end
      assign words[g*32 +: 32] = word_q;
   end
endmodule

// File: rtl/evt_submit_gate.sv
module evt_submit_gate #(
   parameter int N_CORES = 2,
   localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic [63:0]        ts,
   input  logic [63:0]        time_now,
   input  logic [7:0]         core,
   input  logic [N_CORES-1:0] fifo_full,
   input  logic [N_CORES-1:0] link_down,
   output logic [CW-1:0]      sel,
   output logic               underflow,
   output logic               link_bad,
   output logic               stall
);
   logic core_ok;

   always_comb begin
      core_ok   = (int'(core) < N_CORES);
      sel       = core_ok ? core[CW-1:0] : '0;
      underflow = (ts < time_now);
      link_bad  = !core_ok || link_down[sel];
      stall     = !underflow && !link_bad && fifo_full[sel];
   end
endmodule

// File: rtl/evt_submit_regs.sv
module evt_submit_regs
   import evt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_WORDS = 2,
   parameter int N_CORES    = 2,
   localparam int DW   = 32 * DATA_WORDS,
   localparam int CW   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
   localparam int IDXW = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_ack,
   output logic               bus_err,
   input  logic [63:0]        time_now,
   input  logic [N_CORES-1:0] fifo_full,
   input  logic [N_CORES-1:0] link_down,
   output logic [N_CORES-1:0] ev_push,
   output logic [63:0]        ev_timestamp,
   output logic [15:0]        ev_channel,
   output logic [7:0]         ev_addr,
   output logic [DW-1:0]      ev_data
);
   if (N_CORES < 1 || N_CORES > 256) begin : g_bad_cores
      $error("N_CORES must lie in 1..256");
   end
   if (DATA_WORDS < 1 || REG_DATA0 + DATA_WORDS > (1 << ADDR_W)) begin : g_bad_words
      $error("data words do not fit the address space");
   end
   if (IDXW > ADDR_W) begin : g_bad_idx
      $error("index wider than address");
   end

   logic [63:0]        ts_commit;
   logic [DW-1:0]      data_words;
   logic [DW-1:0]      sub_data;
   target_t            tgt_q;
   logic [N_FLAGS-1:0] flags_q;
   logic               resp_q;
   logic [CW-1:0]      sel;
   logic               uf, link_bad, stall;

   logic               open_req, is_submit, accept, fail, go;
   logic               wr_ts_lo, wr_ts_hi, data_sel;
   logic [ADDR_W-1:0]  data_off;
   logic [IDXW-1:0]    data_idx;

   always_comb begin
      open_req  = bus_req && !resp_q;
      is_submit = bus_we && (bus_addr == ADDR_W'(REG_DATA0));
      accept    = open_req && !(is_submit && stall);
      fail      = accept && is_submit && (uf || link_bad);
      go        = accept && is_submit && !uf && !link_bad;
      wr_ts_lo  = accept && bus_we && (bus_addr == ADDR_W'(REG_TS_LO));
      wr_ts_hi  = accept && bus_we && (bus_addr == ADDR_W'(REG_TS_HI));
      data_off  = bus_addr - ADDR_W'(REG_DATA0);
      data_idx  = data_off[IDXW-1:0];
      data_sel  = (bus_addr >= ADDR_W'(REG_DATA0)) &&
                  (int'(data_off) < DATA_WORDS);
   end

   evt_ts_shadow u_ts (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_ts_lo), .wr_hi(wr_ts_hi),
      .wdata(bus_wdata), .ts_commit(ts_commit)
   );

   evt_data_regs #(.WORDS(DATA_WORDS)) u_data (
      .clk(clk), .rst_n(rst_n), .clr(wr_ts_lo || wr_ts_hi),
      .wr_en(accept && bus_we && data_sel), .wr_idx(data_idx),
      .wdata(bus_wdata), .words(data_words)
   );

   evt_submit_gate #(.N_CORES(N_CORES)) u_gate (
      .ts(ts_commit), .time_now(time_now), .core(tgt_q.core),
      .fifo_full(fifo_full), .link_down(link_down), .sel(sel),
      .underflow(uf), .link_bad(link_bad), .stall(stall)
   );

   if (DATA_WORDS > 1) begin : g_multi
      assign sub_data = {data_words[DW-1:32], bus_wdata};
   end else begin : g_single
      assign sub_data = bus_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q     <= '0;
         flags_q   <= '0;
         resp_q    <= 1'b0;
         bus_ack   <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
         ev_push   <= '0;
         ev_timestamp <= '0;
         ev_channel   <= '0;
         ev_addr      <= '0;
         ev_data      <= '0;
      end else begin
         resp_q  <= accept;
         bus_ack <= accept && !fail;
         bus_err <= fail;
         ev_push <= '0;
         if (accept && bus_we && bus_addr == ADDR_W'(REG_TARGET))
            tgt_q <= target_t'(bus_wdata);
         if (accept && bus_we && bus_addr == ADDR_W'(REG_STATUS))
            flags_q <= '0;
         if (open_req && is_submit && stall)
            flags_q[FLAG_WAIT] <= 1'b1;
         if (fail && uf)       flags_q[FLAG_UNDERFLOW] <= 1'b1;
         if (fail && link_bad) flags_q[FLAG_LINK]      <= 1'b1;
         if (go) begin
            ev_push[sel] <= 1'b1;
            ev_timestamp <= ts_commit;
            ev_channel   <= tgt_q.chan;
            ev_addr      <= tgt_q.addr;
            ev_data      <= sub_data;
         end
         if (accept && !bus_we) begin
            if (bus_addr == ADDR_W'(REG_TS_LO))       bus_rdata <= ts_commit[31:0];
            else if (bus_addr == ADDR_W'(REG_TS_HI))  bus_rdata <= ts_commit[63:32];
            else if (bus_addr == ADDR_W'(REG_TARGET)) bus_rdata <= tgt_q;
            else if (bus_addr == ADDR_W'(REG_STATUS)) bus_rdata <= 32'(flags_q);
            else if (data_sel)   bus_rdata <= data_words[int'(data_idx)*32 +: 32];
            else                 bus_rdata <= '0;
         end
      end
   end
endmodule

// File: rtl/evt_submit_chk.sv
module evt_submit_chk #(
   parameter int N_CORES = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_ack,
   input logic               bus_err,
   input logic [N_CORES-1:0] ev_push,
   input logic [63:0]        ev_timestamp,
   input logic [63:0]        time_now,
   input logic [N_CORES-1:0] fifo_full
);
   assert_one_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ack && bus_err));

   assert_single_cycle_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack || bus_err) |=> !(bus_ack || bus_err));

   assert_push_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ev_push));

   assert_push_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_push != '0) |-> bus_ack);

   assert_no_push_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (ev_push == '0));

   assert_no_past_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_push != '0) |-> (ev_timestamp >= $past(time_now)));

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assert_push_needs_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ev_push[c] |-> !$past(fifo_full[c]));
   end
endmodule

bind evt_submit_regs evt_submit_chk #(.N_CORES(N_CORES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .bus_err(bus_err),
   .ev_push(ev_push), .ev_timestamp(ev_timestamp), .time_now(time_now),
   .fifo_full(fifo_full)
);

// File: tb/evt_submit_regs_tb.sv
module evt_submit_regs_tb;
   localparam int AW = 4;
   localparam int NW = 2;
   localparam int NC = 2;
   localparam int DW = 32 * NW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_ack, bus_err;
   logic [63:0]   time_now = '0;
   logic [NC-1:0] fifo_full = '0;
   logic [NC-1:0] link_down = '0;
   logic [NC-1:0] ev_push;
   logic [63:0]   ev_timestamp;
   logic [15:0]   ev_channel;
   logic [7:0]    ev_addr;
   logic [DW-1:0] ev_data;

   always #4 clk = ~clk;

   evt_submit_regs #(.ADDR_W(AW), .DATA_WORDS(NW), .N_CORES(NC)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .bus_err(bus_err), .time_now(time_now),
      .fifo_full(fifo_full), .link_down(link_down), .ev_push(ev_push),
      .ev_timestamp(ev_timestamp), .ev_channel(ev_channel),
      .ev_addr(ev_addr), .ev_data(ev_data)
   );

   int n_checks = 0;
   int n_fail = 0;
   int push_cnt = 0;
   logic [NC-1:0] cap_push;
   logic [63:0]   cap_ts;
   logic [15:0]   cap_chan;
   logic [7:0]    cap_addr;
   logic [DW-1:0] cap_data;

   always @(negedge clk) begin
      if (rst_n && ev_push != '0) begin
         push_cnt++;
         cap_push = ev_push;
         cap_ts   = ev_timestamp;
         cap_chan = ev_channel;
         cap_addr = ev_addr;
         cap_data = ev_data;
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input int addr, input logic [31:0] d,
                            output logic got_err, output int waits);
      logic done;
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
      waits = 0; done = 1'b0;
      while (!done) begin
         @(negedge clk);
         if (bus_ack || bus_err) done = 1'b1;
         else waits++;
      end
      got_err = bus_err;
      check("R10 ack_xor_err", {63'b0, bus_ack ^ bus_err}, 64'd1);
      bus_req = 1'b0;
   endtask

   task automatic bus_read(input int addr, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
      do @(negedge clk); while (!(bus_ack || bus_err));
      d = bus_rdata;
      bus_req = 1'b0;
   endtask

   function automatic logic exp_fail(input logic [63:0] ts, input logic [63:0] now,
                                     input int core, input logic [NC-1:0] lk);
      if (core >= NC) return 1'b1;
      if (lk[core]) return 1'b1;
      return ts < now;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
      $finish;
   end

   initial begin
      logic e;
      int w, p0;
      logic [31:0] r;
      void'($urandom(32'h1d2c3b4a));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ack", {63'b0, bus_ack}, 64'd0);
      check("R1 err", {63'b0, bus_err}, 64'd0);
      check("R1 push", {62'b0, ev_push}, 64'd0);
      bus_read(3, r); check("R1 status", {32'b0, r}, 64'd0);
      bus_read(0, r); check("R1 ts", {32'b0, r}, 64'd0);

      // R2 staging and commit
      bus_write(1, 32'h1234, e, w);
      bus_read(1, r); check("R2 hi_alone", {32'b0, r}, 64'd0);
      bus_write(0, 32'h100, e, w);
      bus_read(1, r); check("R2 hi_commit", {32'b0, r}, 64'h1234);
      bus_read(0, r); check("R2 lo_commit", {32'b0, r}, 64'h100);

      // R5 timestamp write clears data
      bus_write(5, 32'hAAAA, e, w);
      bus_read(5, r); check("R5 latched", {32'b0, r}, 64'hAAAA);
      bus_write(1, 32'h0, e, w);
      bus_read(5, r); check("R5 cleared", {32'b0, r}, 64'd0);

      // R3 / R4 submission with four-plus writes
      time_now = 64'h10;
      bus_write(0, 32'h200, e, w);
      bus_write(2, {8'd1, 16'hBEEF, 8'h5A}, e, w);
      p0 = push_cnt;
      bus_write(5, 32'hCAFE, e, w);
      @(negedge clk);
      check("R4 upper_no_push", 64'(push_cnt), 64'(p0));
      bus_write(4, 32'h1111, e, w);
      @(negedge clk);
      check("R4 err", {63'b0, e}, 64'd0);
      check("R4 pushed", 64'(push_cnt), 64'(p0 + 1));
      check("R3 core_line", {62'b0, cap_push}, 64'b10);
      check("R3 chan", {48'b0, cap_chan}, 64'hBEEF);
      check("R3 addr", {56'b0, cap_addr}, 64'h5A);
      check("R4 data", cap_data, 64'h0000CAFE_00001111);
      check("R4 ts", cap_ts, 64'h200);

      // R6 wait states on full queue
      fifo_full = 2'b10;
      p0 = push_cnt;
      fork
         bus_write(4, 32'h2222, e, w);
         begin repeat (6) @(negedge clk); fifo_full = 2'b00; end
      join
      @(negedge clk);
      check("R6 waited", {63'b0, (w >= 5)}, 64'd1);
      check("R6 one_push", 64'(push_cnt), 64'(p0 + 1));
      check("R6 data", cap_data, 64'h0000CAFE_00002222);
      bus_read(3, r); check("R6 wait_flag", {32'b0, r}, 64'h2);

      // R9 clear
      bus_write(3, 32'h0, e, w);
      bus_read(3, r); check("R9 cleared", {32'b0, r}, 64'd0);

      // R7 underflow
      time_now = 64'h300;
      p0 = push_cnt;
      bus_write(4, 32'h3, e, w);
      @(negedge clk);
      check("R7 err", {63'b0, e}, 64'd1);
      check("R7 no_push", 64'(push_cnt), 64'(p0));
      bus_read(3, r); check("R7 flag", {32'b0, r}, 64'h1);
      bus_write(3, 32'h0, e, w);

      // R8 link down on selected core, then other core, then bad core
      time_now = 64'h0;
      link_down = 2'b10;
      bus_write(4, 32'h4, e, w);
      check("R8 link_err", {63'b0, e}, 64'd1);
      bus_read(3, r); check("R8 link_flag", {32'b0, r}, 64'h4);
      bus_write(3, 32'h0, e, w);
      link_down = 2'b01;
      p0 = push_cnt;
      bus_write(4, 32'h5, e, w);
      @(negedge clk);
      check("R8 other_core_ok", {63'b0, e}, 64'd0);
      check("R8 other_core_push", 64'(push_cnt), 64'(p0 + 1));
      link_down = 2'b00;
      bus_write(2, {8'd5, 16'h1, 8'h2}, e, w);
      bus_write(4, 32'h6, e, w);
      check("R8 bad_core", {63'b0, e}, 64'd1);
      bus_read(3, r); check("R8 bad_core_flag", {32'b0, r}, 64'h4);
      bus_write(3, 32'h0, e, w);

      // random submissions
      for (int i = 0; i < 60; i++) begin
         logic [31:0] tsl, d0, d1;
         logic [15:0] ch;
         logic [7:0]  ad;
         logic [NC-1:0] lk;
         int core;
         logic xf;
         tsl = $urandom & 32'hFFFF;
         time_now = 64'($urandom & 32'hFFFF);
         core = $urandom % 3;
         lk = NC'($urandom % 4);
         ch = 16'($urandom); ad = 8'($urandom);
         d0 = $urandom; d1 = $urandom;
         link_down = lk;
         bus_write(1, 32'h0, e, w);
         bus_write(0, tsl, e, w);
         bus_write(2, {8'(core), ch, ad}, e, w);
         bus_write(5, d1, e, w);
         p0 = push_cnt;
         bus_write(4, d0, e, w);
         @(negedge clk);
         xf = exp_fail({32'b0, tsl}, time_now, core, lk);
         check("R7/R8 rand_err", {63'b0, e}, {63'b0, xf});
         check("R4 rand_push", 64'(push_cnt), 64'(p0 + (xf ? 0 : 1)));
         if (!xf) begin
            check("R3 rand_core", {62'b0, cap_push}, 64'(1 << core));
            check("R3 rand_target", {40'b0, cap_chan, cap_addr}, {40'b0, ch, ad});
            check("R4 rand_data", cap_data, {d1, d0});
         end
         bus_write(3, 32'h0, e, w);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule